// File: doc/BRIEF.md
# Three-Strobe ADC Sample Sequencer

This block sits on the host side of a 16-bit, single-channel analog-to-digital converter. The converter is reached over a byte-wide data bus. The converter is driven by an active-low chip-select strobe and a read/convert level. It acts on the level seen at each falling edge of the strobe, and that level means something different at each of the three edges of one sample. The first edge wakes the converter and starts acquisition. The second edge starts the conversion and also carries the reference power-down request. The third edge puts the finished result on the bus. Between the second and third edges the sequencer waits for the converter's active-low end-of-conversion line, and a timeout guards that wait.

The result comes back as two bytes. A byte-select output picks the byte: 1 selects bits 15..8 and 0 selects bits 7..0. The sequencer reads the upper byte first, switches the select, lets the bus settle, and then reads the lower byte. It then presents the assembled word together with a one-cycle valid pulse. A host starts a sample with a single-cycle `start` and supplies the power-down choice on `refSleep` in that same cycle. When the previous sample powered the reference down, the sequencer adds a wake-up delay before the next conversion edge.

Top module: `convSequencer`

## Requirements
- R1: Out of reset, `csN` is 1, `rdConv` is 0, `hiByteSel` is 1, and `busy`, `resultValid` and `timeoutErr` are 0.
- R2: Every sample produces exactly three falling edges of `csN`. `rdConv` is 0 at the first of them.
- R3: At the second falling edge, `rdConv` equals the `refSleep` value captured with `start` (1 requests reference power-down after conversion).
- R4: At the third falling edge, `rdConv` is 1. That edge is never issued while `eocN` is still 1.
- R5: `rdConv` holds its value for at least SETUP_CLKS clocks before each falling edge of `csN` and stays unchanged while `csN` is low. `csN` stays low for HOLD_CLKS clocks at the first and second edges, and for HOLD_CLKS+2*SETTLE_CLKS clocks at the third.
- R6: During the third low phase, the byte read with `hiByteSel`=1 becomes `result[15:8]`. `hiByteSel` then falls, and after SETTLE_CLKS clocks the byte on the bus becomes `result[7:0]`. `resultValid` is high for exactly one clock with the word.
- R7: `busy` rises the clock after an accepted `start` and falls in the clock in which `resultValid` or a new `timeoutErr` appears. A `start` while busy is ignored.
- R8: If `eocN` stays 1 for TIMEOUT_CLKS clocks of waiting, `timeoutErr` is set HOLD_CLKS+TIMEOUT_CLKS clocks after the second falling edge, and the block returns to idle. The next accepted `start` clears the flag.
- R9: The spacing between the first and second falling edges is HOLD_CLKS+SETUP_CLKS clocks. When the previous sample requested reference power-down, that spacing grows by WAKE_CLKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one sample; honoured only in idle |
| refSleep | input | 1 | Power the reference down after this sample's conversion |
| eocN | input | 1 | Converter end-of-conversion, low when done |
| dataIn | input | 8 | Byte bus from the converter |
| csN | output | 1 | Chip-select strobe to the converter |
| rdConv | output | 1 | Read/convert level to the converter |
| hiByteSel | output | 1 | Byte select: 1 upper byte, 0 lower byte |
| busy | output | 1 | Sample in progress |
| result | output | 16 | Assembled conversion word |
| resultValid | output | 1 | One-cycle qualifier for `result` |
| timeoutErr | output | 1 | End-of-conversion wait expired |

## Verification
The assertions assume that `eocN` only falls after a conversion edge, and that `dataIn` is driven by a converter that follows `csN` and `hiByteSel`. They make no demand on when `start` arrives. The bench's converter model follows the same rules. It counts the strobe edges, lowers `eocN` only after a programmed delay that follows the second edge, releases it when the read phase ends, and drives `dataIn` only during the third low phase. In the timeout case `eocN` is left high, and the model resynchronises its edge count when the error appears.

// File: rtl/convSeqPkg.sv
package convSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_WAKE,
    ST_WAITEOC,
    ST_READHI,
    ST_READLO
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capHi;
    logic capLo;
    logic setErr;
    logic clrErr;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/convSeqCtrl.sv
module convSeqCtrl
  import convSeqPkg::*;
#(
  parameter int SETUP_CLKS   = 2,
  parameter int HOLD_CLKS    = 2,
  parameter int SETTLE_CLKS  = 2,
  parameter int WAKE_CLKS    = 20,
  parameter int TIMEOUT_CLKS = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      refSleep,
  input  logic      eocN,
  output logic      csN,
  output logic      rdConv,
  output logic      hiByteSel,
  output logic      busy,
  output dpStrobe_t strobe
);

  localparam int DLY_MAX = maxOf(maxOf(SETUP_CLKS, HOLD_CLKS), maxOf(SETTLE_CLKS, WAKE_CLKS));
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam int TW = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [DW-1:0] SETUP_LD  = DW'(SETUP_CLKS - 1);
  localparam logic [DW-1:0] HOLD_LD   = DW'(HOLD_CLKS - 1);
  localparam logic [DW-1:0] SETTLE_LD = DW'(SETTLE_CLKS - 1);
  localparam logic [DW-1:0] WAKE_LD   = DW'(WAKE_CLKS - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TIMEOUT_CLKS - 1);

  seqState_e     state;
  logic [DW-1:0] dlyCnt;
  logic [TW-1:0] waitCnt;
  logic [1:0]    edgeIdx;     // 0 acquire, 1 convert, 2 read
  logic          cfgSleep;    // power-down request of current sample
  logic          wakePending; // reference was powered down last sample
  logic          dlyDone;
  logic          edgeLevel;

  assign dlyDone = (dlyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      dlyCnt      <= '0;
      waitCnt     <= '0;
      edgeIdx     <= 2'd0;
      cfgSleep    <= 1'b0;
      wakePending <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          cfgSleep <= refSleep;
          edgeIdx  <= 2'd0;
          dlyCnt   <= SETUP_LD;
          state    <= ST_SETUP;
        end
        ST_SETUP: if (dlyDone) begin
          dlyCnt <= HOLD_LD;
          state  <= ST_LOW;
        end else dlyCnt <= dlyCnt - 1'b1;
        ST_LOW: if (dlyDone) begin
          case (edgeIdx)
            2'd0: begin
              edgeIdx <= 2'd1;
              if (wakePending) begin
                wakePending <= 1'b0;
                dlyCnt      <= WAKE_LD;
                state       <= ST_WAKE;
              end else begin
                dlyCnt <= SETUP_LD;
                state  <= ST_SETUP;
              end
            end
            2'd1: begin
              wakePending <= cfgSleep;
              waitCnt     <= '0;
              state       <= ST_WAITEOC;
            end
            default: begin
              dlyCnt <= SETTLE_LD;
              state  <= ST_READHI;
            end
          endcase
        end else dlyCnt <= dlyCnt - 1'b1;
        ST_WAKE: if (dlyDone) begin
          dlyCnt <= SETUP_LD;
          state  <= ST_SETUP;
        end else dlyCnt <= dlyCnt - 1'b1;
        ST_WAITEOC: if (!eocN) begin
          edgeIdx <= 2'd2;
          dlyCnt  <= SETUP_LD;
          state   <= ST_SETUP;
        end else if (waitCnt == TMO_LAST) begin
          state <= ST_IDLE;
        end else waitCnt <= waitCnt + 1'b1;
        ST_READHI: if (dlyDone) begin
          dlyCnt <= SETTLE_LD;
          state  <= ST_READLO;
        end else dlyCnt <= dlyCnt - 1'b1;
        ST_READLO: if (dlyDone) state <= ST_IDLE;
                   else dlyCnt <= dlyCnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (edgeIdx)
      2'd0:    edgeLevel = 1'b0;
      2'd1:    edgeLevel = cfgSleep;
      default: edgeLevel = 1'b1;
    endcase
  end

  always_comb begin
    csN       = !(state inside {ST_LOW, ST_READHI, ST_READLO});
    rdConv    = (state inside {ST_SETUP, ST_LOW, ST_READHI, ST_READLO}) ? edgeLevel : 1'b0;
    hiByteSel = (state != ST_READLO);
    busy      = (state != ST_IDLE);
    strobe.capHi  = (state == ST_READHI) && dlyDone;
    strobe.capLo  = (state == ST_READLO) && dlyDone;
    strobe.setErr = (state == ST_WAITEOC) && eocN && (waitCnt == TMO_LAST);
    strobe.clrErr = (state == ST_IDLE) && start;
  end

endmodule

// File: rtl/convSeqData.sv
module convSeqData
  import convSeqPkg::*;
#(
  parameter int BUS_W = 8,
  localparam int WORD_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [WORD_W-1:0] result,
  output logic              resultValid,
  output logic              timeoutErr
);

  logic [BUS_W-1:0] hiByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte      <= '0;
      result      <= '0;
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      resultValid <= strobe.capLo;
      if (strobe.capHi) hiByte <= dataIn;
      if (strobe.capLo) result <= {hiByte, dataIn};
      if (strobe.setErr)      timeoutErr <= 1'b1;
      else if (strobe.clrErr) timeoutErr <= 1'b0;
    end
  end

endmodule

// File: rtl/convSequencer.sv
module convSequencer
  import convSeqPkg::*;
#(
  parameter int SETUP_CLKS   = 2,
  parameter int HOLD_CLKS    = 2,
  parameter int SETTLE_CLKS  = 2,
  parameter int WAKE_CLKS    = 20,
  parameter int TIMEOUT_CLKS = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        refSleep,
  input  logic        eocN,
  input  logic [7:0]  dataIn,
  output logic        csN,
  output logic        rdConv,
  output logic        hiByteSel,
  output logic        busy,
  output logic [15:0] result,
  output logic        resultValid,
  output logic        timeoutErr
);

  dpStrobe_t strobe;

  convSeqCtrl #(
    .SETUP_CLKS(SETUP_CLKS), .HOLD_CLKS(HOLD_CLKS), .SETTLE_CLKS(SETTLE_CLKS),
    .WAKE_CLKS(WAKE_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .refSleep(refSleep), .eocN(eocN),
    .csN(csN), .rdConv(rdConv), .hiByteSel(hiByteSel), .busy(busy), .strobe(strobe)
  );

  convSeqData #(.BUS_W(8)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .result(result), .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

endmodule

// File: rtl/convSeqChecker.sv
module convSeqChecker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic rdConv,
  input logic hiByteSel,
  input logic busy,
  input logic resultValid,
  input logic timeoutErr
);

  p_rdconv_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $stable(rdConv));

  p_rdconv_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(rdConv));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_byte_switch_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hiByteSel) |-> (!csN && rdConv));

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !busy);

  p_cs_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> !busy);

endmodule

bind convSequencer convSeqChecker chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdConv(rdConv), .hiByteSel(hiByteSel),
  .busy(busy), .resultValid(resultValid), .timeoutErr(timeoutErr)
);

// File: tb/convSequencer_test.sv
module convSequencer_test;

  localparam int SETUP   = 2;
  localparam int HOLD    = 2;
  localparam int SETTLE  = 2;
  localparam int WAKE    = 20;
  localparam int TIMEOUT = 200;

  // {sample, refSleep, conversion delay}
  localparam logic [24:0] VEC [6] = '{
    {16'h0000, 1'b0, 8'd3},
    {16'hFFFF, 1'b1, 8'd10},
    {16'h8001, 1'b1, 8'd0},
    {16'h1234, 1'b0, 8'd50},
    {16'hA5C3, 1'b1, 8'd7},
    {16'h7FFE, 1'b0, 8'd1}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, refSleep = 1'b0, eocN = 1'b1;
  logic [7:0]  dataIn;
  logic        csN, rdConv, hiByteSel, busy, resultValid, timeoutErr;
  logic [15:0] result;

  convSequencer #(
    .SETUP_CLKS(SETUP), .HOLD_CLKS(HOLD), .SETTLE_CLKS(SETTLE),
    .WAKE_CLKS(WAKE), .TIMEOUT_CLKS(TIMEOUT)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .refSleep(refSleep), .eocN(eocN),
    .dataIn(dataIn), .csN(csN), .rdConv(rdConv), .hiByteSel(hiByteSel),
    .busy(busy), .result(result), .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  always #10 clk = ~clk;

  int nRun = 0, nFail = 0;
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model state
  logic [15:0] smp = '0;
  int  convDelay = 0, eocCnt = -1, respEdge = 0;
  bit  noEoc = 0, curSleep = 0, sleepPrev = 0, readPhase = 0;
  int  cyc = 0, lowLen = 0, rdStable = 0, tFall0 = 0, tFall1 = 0;
  int  totalFalls = 0, validCount = 0;
  logic prevCs = 1'b1, prevRd = 1'b0, prevErr = 1'b0;

  assign dataIn = (readPhase && !csN) ? (hiByteSel ? smp[15:8] : smp[7:0]) : 8'h00;

  always @(negedge clk) if (rstN) begin
    cyc++;
    if (resultValid) validCount++;
    if (rdConv === prevRd) rdStable++; else rdStable = 0;
    if (eocCnt > 0) eocCnt--;
    else if (eocCnt == 0) begin eocN = 1'b0; eocCnt = -1; end
    if (prevCs && !csN) begin
      totalFalls++;
      lowLen = 0;
      chk("R5", "rdConv setup clocks >= SETUP", (rdStable >= SETUP), 1);
      case (respEdge)
        0: begin chk("R2", "rdConv at first edge", rdConv, 0); tFall0 = cyc; end
        1: begin
          chk("R3", "rdConv at second edge", rdConv, curSleep);
          chk("R9", "first-to-second edge spacing", cyc - tFall0,
              HOLD + SETUP + (sleepPrev ? WAKE : 0));
          sleepPrev = curSleep;
          tFall1 = cyc;
          if (!noEoc) eocCnt = convDelay;
        end
        default: begin
          chk("R4", "rdConv at third edge", rdConv, 1);
          chk("R4", "eocN low before third edge", eocN, 0);
          readPhase = 1;
        end
      endcase
      respEdge = (respEdge + 1) % 3;
    end
    if (!csN) lowLen++;
    if (!prevCs && csN) begin
      if (respEdge == 0) begin
        chk("R5", "third low phase length", lowLen, HOLD + 2 * SETTLE);
        readPhase = 0;
        eocN = 1'b1;
      end else chk("R5", "low phase length", lowLen, HOLD);
    end
    if (timeoutErr && !prevErr) begin
      chk("R8", "timeout delay after second edge", cyc - tFall1, HOLD + TIMEOUT);
      chk("R8", "busy at timeout", busy, 0);
      respEdge = 0;
    end
    prevCs = csN; prevRd = rdConv; prevErr = timeoutErr;
  end

  task automatic pulseStart(input bit sl);
    @(negedge clk);
    start = 1'b1; refSleep = sl;
    @(negedge clk);
    start = 1'b0; refSleep = 1'b0;
  endtask

  task automatic runSample(input logic [15:0] v, input bit sl, input int dly);
    smp = v; curSleep = sl; convDelay = dly; noEoc = 0;
    pulseStart(sl);
    chk("R7", "busy after start", busy, 1);
    for (int n = 0; n < 2000 && !resultValid; n++) @(negedge clk);
    chk("R6", "resultValid seen", resultValid, 1);
    chk("R6", "assembled word", result, v);
    chk("R7", "busy with result", busy, 0);
    @(negedge clk);
    chk("R6", "valid lasts one clock", resultValid, 0);
  endtask

  task automatic finishRun;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk("WD", "watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "csN", csN, 1);
    chk("R1", "rdConv", rdConv, 0);
    chk("R1", "hiByteSel", hiByteSel, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "resultValid", resultValid, 0);
    chk("R1", "timeoutErr", timeoutErr, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    foreach (VEC[i]) runSample(VEC[i][24:9], VEC[i][8], int'(VEC[i][7:0]));

    // R7: start while busy is ignored
    begin
      int falls0, valid0;
      falls0 = totalFalls; valid0 = validCount;
      smp = 16'h5A5A; curSleep = 0; convDelay = 5; noEoc = 0;
      pulseStart(1'b0);
      repeat (4) @(negedge clk);
      pulseStart(1'b1);
      for (int n = 0; n < 2000 && !resultValid; n++) @(negedge clk);
      chk("R6", "word after ignored start", result, 16'h5A5A);
      repeat (40) @(negedge clk);
      chk("R7", "edges for one sample", totalFalls - falls0, 3);
      chk("R7", "valid pulses for one sample", validCount - valid0, 1);
      chk("R7", "idle after ignored start", busy, 0);
    end

    // R8: conversion never completes
    noEoc = 1; curSleep = 0;
    pulseStart(1'b0);
    for (int n = 0; n < 1000 && !timeoutErr; n++) @(negedge clk);
    chk("R8", "timeoutErr set", timeoutErr, 1);
    chk("R8", "idle after timeout", busy, 0);
    repeat (5) @(negedge clk);
    chk("R8", "no edge while idle after timeout", csN, 1);
    chk("R8", "no result on timeout", resultValid, 0);
    runSample(16'hC0DE, 1'b0, 4);
    chk("R8", "timeoutErr cleared by start", timeoutErr, 0);

    // R9: wake delay after a power-down sample, then none
    runSample(16'h0F0F, 1'b1, 2);
    runSample(16'hF00F, 1'b0, 2);
    runSample(16'h00FF, 1'b0, 9);

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule